// File: doc/BRIEF.md
# Edge-Select Input Capture Channel

This block is one channel of a general-purpose timer that measures time between events on an external pin. A counter advances once for every cycle in which the prescaled tick strobe is high. When the chosen edge appears on the chosen input pin, the counter value is copied into a capture register. The counter can also be restarted at that same moment. With restart enabled, every capture holds the number of ticks since the previous capture, so software reads a period measurement directly without doing any subtraction.

The input path works in this order. A multiplexer picks one of several pins, and an optional inversion is applied to it. Two synchronizer flip-flops follow, then an optional digital filter, then the edge detector. Each capture sets a sticky edge flag. That flag is signalled through exactly one of two paths: an interrupt request or a DMA request. The two path enables exclude each other, so turning one on turns the other off. The DMA request drops when the capture register is read. While a capture mode is active, the pin's output enable is forced off.

Top module: `edgecap_channel`

## Requirements
- R1: The capture input is `pins_i[pin_sel_i]` XOR `invert_i`. Pins that are not selected have no effect on the flag or on the capture register.
- R2: With the filter bypassed, a change on the selected input reaches the edge detector through two flip-flops. The capture register and the flag update on the third rising clock edge after the input changes.
- R3: `edge_mode_i` selects the capture edge: 0 = capture disabled, 1 = rising edge, 2 = falling edge, 3 = either edge. While the mode is 0, `cap_o` does not change.
- R4: `cnt_o` adds one, wrapping at 2^CNT_W, in every cycle in which `tick_i` is high. A capture stores the value `cnt_o` holds in the cycle of the event.
- R5: When `reload_i` is high, a capture event sets the counter to 0 at the same edge, and `tick_i` is ignored in that cycle.
- R6: `flag_o` is set by a capture and stays set until `flag_clr_i` is pulsed. If a capture and a clear occur in the same cycle, the capture wins.
- R7: A pulse on `set_irq_en_i` turns the interrupt route on and the DMA route off. A pulse on `set_dma_en_i` does the opposite. If both are pulsed together, the interrupt route wins. `irq_o` is the flag gated by the interrupt route.
- R8: A capture taken while the DMA route is on raises `dma_o`. A pulse on `cap_rd_i` clears it, unless a new capture occurs in the same cycle. `dma_o` is low whenever the DMA route is off.
- R9: `pin_oe_o` equals `oe_req_i` while `edge_mode_i` is 0, and is 0 in any capture mode.
- R10: When `filt_len_i` is 0, the filter is bypassed. When `filt_len_i` is nonzero, a new input level is accepted only after the synchronized input has disagreed with the current filtered level for `filt_len_i` consecutive clocks. Shorter pulses are ignored.
- R11: A synchronous reset clears the counter, the capture register, the flag, both route enables and the DMA request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pins_i | input | NUM_PINS | Candidate capture pins (asynchronous) |
| pin_sel_i | input | SEL_W | Index of the capture pin |
| invert_i | input | 1 | Invert the selected pin |
| edge_mode_i | input | 2 | Capture edge: 0 off, 1 rise, 2 fall, 3 both |
| reload_i | input | 1 | Restart the counter on each capture |
| filt_len_i | input | FILT_W | Filter length in clocks, 0 = bypass |
| tick_i | input | 1 | Prescaled count-enable strobe |
| oe_req_i | input | 1 | Requested pin output enable |
| set_irq_en_i | input | 1 | Select the interrupt route |
| set_dma_en_i | input | 1 | Select the DMA route |
| flag_clr_i | input | 1 | Clear the edge flag |
| cap_rd_i | input | 1 | Capture register read strobe |
| cnt_o | output | CNT_W | Running counter |
| cap_o | output | CNT_W | Capture register |
| flag_o | output | 1 | Sticky edge flag |
| irq_o | output | 1 | Interrupt request |
| dma_o | output | 1 | DMA request |
| pin_oe_o | output | 1 | Pin output enable |

## Verification
The assertions assume that every control input except `pins_i` is synchronous to `clk`. They also assume that `pin_sel_i` names an existing pin. With the default four pins, every select code is valid. The bench changes all inputs two time units after the falling edge, including the pins, so the synchronizer never sees a level change close to a sampling edge. The reference model therefore resolves every level on a known cycle. The random phase may pulse both route strobes together and may combine a read or a clear with a capture, because the block defines a winner for each of those collisions.

// File: rtl/edgecap_pkg.sv
package edgecap_pkg;

    typedef enum logic [1:0] {
        CAP_OFF  = 2'd0,
        CAP_RISE = 2'd1,
        CAP_FALL = 2'd2,
        CAP_BOTH = 2'd3
    } cap_mode_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_pair_t;

    function automatic logic mode_hit(cap_mode_e m, edge_pair_t e);
        case (m)
            CAP_RISE: return e.rise;
            CAP_FALL: return e.fall;
            CAP_BOTH: return e.rise | e.fall;
            default:  return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/cap_insync.sv
module cap_insync #(
    parameter int NUM_PINS = 4,
    parameter int FILT_W   = 4,
    localparam int SEL_W   = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] pins_i,
    input  logic [SEL_W-1:0]    sel_i,
    input  logic                invert_i,
    input  logic [FILT_W-1:0]   filt_len_i,
    output logic                lvl_o
);
    logic              raw;
    logic [1:0]        sync_q;
    logic              s2;
    logic              fq;
    logic [FILT_W-1:0] fcnt_q;
    logic [FILT_W:0]   fcnt_inc;
    logic              bypass;

    assign raw      = pins_i[sel_i] ^ invert_i;
    assign s2       = sync_q[1];
    assign bypass   = (filt_len_i == '0);
    assign fcnt_inc = {1'b0, fcnt_q} + {{FILT_W{1'b0}}, 1'b1};

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            fq     <= 1'b0;
            fcnt_q <= '0;
        end else begin
            sync_q <= {sync_q[0], raw};
            if (bypass) begin
                fq     <= s2;
                fcnt_q <= '0;
            end else if (s2 == fq) begin
                fcnt_q <= '0;
            end else if (fcnt_inc >= {1'b0, filt_len_i}) begin
                fq     <= s2;
                fcnt_q <= '0;
            end else begin
                fcnt_q <= fcnt_inc[FILT_W-1:0];
            end
        end
    end

    assign lvl_o = bypass ? s2 : fq;

    // R10: an agreeing sample never moves the filtered level
    p_filt_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (!bypass && (s2 == fq)) |=> (fq == $past(fq)));

endmodule

// File: rtl/cap_edge.sv
module cap_edge
    import edgecap_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      lvl_i,
    input  cap_mode_e mode_i,
    output logic      ev_o
);
    logic       prev_q;
    edge_pair_t edges;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= lvl_i;
    end

    always_comb begin
        edges.rise = lvl_i & ~prev_q;
        edges.fall = ~lvl_i & prev_q;
        ev_o       = mode_hit(mode_i, edges);
    end

    // R3: disabled mode never produces an event
    p_off_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        (mode_i == CAP_OFF) |-> !ev_o);

endmodule

// File: rtl/cap_counter.sv
module cap_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic             ev_i,
    input  logic             reload_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] cap_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_o <= '0;
            cap_o <= '0;
        end else begin
            if (ev_i) cap_o <= cnt_o;
            if (ev_i && reload_i) cnt_o <= '0;
            else if (tick_i)      cnt_o <= cnt_o + 1'b1;
        end
    end

    // R5: restart lands at the capture edge
    p_reload_zero_r5: assert property (@(posedge clk) disable iff (rst)
        (ev_i && reload_i) |=> (cnt_o == '0));
    // R4: capture register takes the pre-edge count
    p_cap_value_r4: assert property (@(posedge clk) disable iff (rst)
        ev_i |=> (cap_o == $past(cnt_o)));

endmodule

// File: rtl/cap_flags.sv
module cap_flags (
    input  logic clk,
    input  logic rst,
    input  logic ev_i,
    input  logic clr_i,
    input  logic rd_i,
    input  logic set_irq_i,
    input  logic set_dma_i,
    output logic flag_o,
    output logic irq_o,
    output logic dma_o
);
    logic irq_en_q;
    logic dma_en_q;
    logic dma_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_o   <= 1'b0;
            irq_en_q <= 1'b0;
            dma_en_q <= 1'b0;
            dma_q    <= 1'b0;
        end else begin
            if (ev_i)       flag_o <= 1'b1;
            else if (clr_i) flag_o <= 1'b0;

            if (ev_i && dma_en_q) dma_q <= 1'b1;
            else if (rd_i)        dma_q <= 1'b0;

            if (set_irq_i) begin
                irq_en_q <= 1'b1;
                dma_en_q <= 1'b0;
            end else if (set_dma_i) begin
                dma_en_q <= 1'b1;
                irq_en_q <= 1'b0;
            end
        end
    end

    assign irq_o = flag_o & irq_en_q;
    assign dma_o = dma_q & dma_en_q;

    // R7: routes are never both on
    p_route_excl_r7: assert property (@(posedge clk) disable iff (rst)
        !(irq_en_q && dma_en_q));
    // R6: flag holds until cleared
    p_flag_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        (flag_o && !clr_i) |=> flag_o);
    // R8: a read without a new capture drops the request
    p_dma_clr_r8: assert property (@(posedge clk) disable iff (rst)
        (rd_i && !ev_i) |=> !dma_o);

endmodule

// File: rtl/edgecap_channel.sv
module edgecap_channel
    import edgecap_pkg::*;
#(
    parameter int NUM_PINS = 4,
    parameter int CNT_W    = 16,
    parameter int FILT_W   = 4,
    localparam int SEL_W   = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] pins_i,
    input  logic [SEL_W-1:0]    pin_sel_i,
    input  logic                invert_i,
    input  logic [1:0]          edge_mode_i,
    input  logic                reload_i,
    input  logic [FILT_W-1:0]   filt_len_i,
    input  logic                tick_i,
    input  logic                oe_req_i,
    input  logic                set_irq_en_i,
    input  logic                set_dma_en_i,
    input  logic                flag_clr_i,
    input  logic                cap_rd_i,
    output logic [CNT_W-1:0]    cnt_o,
    output logic [CNT_W-1:0]    cap_o,
    output logic                flag_o,
    output logic                irq_o,
    output logic                dma_o,
    output logic                pin_oe_o
);
    cap_mode_e mode;
    logic      lvl;
    logic      ev;

    assign mode     = cap_mode_e'(edge_mode_i);
    assign pin_oe_o = (mode == CAP_OFF) ? oe_req_i : 1'b0;

    cap_insync #(.NUM_PINS(NUM_PINS), .FILT_W(FILT_W)) u_insync (
        .clk(clk), .rst(rst), .pins_i(pins_i), .sel_i(pin_sel_i),
        .invert_i(invert_i), .filt_len_i(filt_len_i), .lvl_o(lvl)
    );

    cap_edge u_edge (
        .clk(clk), .rst(rst), .lvl_i(lvl), .mode_i(mode), .ev_o(ev)
    );

    cap_counter #(.CNT_W(CNT_W)) u_counter (
        .clk(clk), .rst(rst), .tick_i(tick_i), .ev_i(ev),
        .reload_i(reload_i), .cnt_o(cnt_o), .cap_o(cap_o)
    );

    cap_flags u_flags (
        .clk(clk), .rst(rst), .ev_i(ev), .clr_i(flag_clr_i), .rd_i(cap_rd_i),
        .set_irq_i(set_irq_en_i), .set_dma_i(set_dma_en_i),
        .flag_o(flag_o), .irq_o(irq_o), .dma_o(dma_o)
    );

    // R3: disabled mode leaves the capture register untouched
    p_off_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (mode == CAP_OFF) |=> $stable(cap_o));
    // R9: any capture mode forces the output driver off
    p_oe_forced_r9: assert property (@(posedge clk) disable iff (rst)
        (mode != CAP_OFF) |-> !pin_oe_o);

endmodule

// File: tb/test_edgecap_channel.sv
module test_edgecap_channel;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  pins = '0;
    logic [1:0]  sel = '0;
    logic        inv = 1'b0;
    logic [1:0]  mode = '0;
    logic        reload = 1'b0;
    logic [3:0]  flen = '0;
    logic        tick = 1'b0;
    logic        oe_req = 1'b0;
    logic        set_irq = 1'b0;
    logic        set_dma = 1'b0;
    logic        fclr = 1'b0;
    logic        rd = 1'b0;
    logic [15:0] cnt, cap;
    logic        flag, irq, dma, oe;

    int tests = 0;
    int fails = 0;
    bit chk_on = 1'b0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    edgecap_channel i_edgecap_channel (
        .clk(clk), .rst(rst), .pins_i(pins), .pin_sel_i(sel), .invert_i(inv),
        .edge_mode_i(mode), .reload_i(reload), .filt_len_i(flen), .tick_i(tick),
        .oe_req_i(oe_req), .set_irq_en_i(set_irq), .set_dma_en_i(set_dma),
        .flag_clr_i(fclr), .cap_rd_i(rd), .cnt_o(cnt), .cap_o(cap),
        .flag_o(flag), .irq_o(irq), .dma_o(dma), .pin_oe_o(oe)
    );

    // behavioural reference model
    bit   mq[$];
    bit   m_fq, m_prev, m_flag, m_irqen, m_dmaen, m_req;
    int   m_fcnt, m_cnt, m_cap;

    always @(posedge clk) begin
        bit s2, lvl, rise, fall, ev;
        if (rst) begin
            mq = {1'b0, 1'b0};
            m_fq = 0; m_prev = 0; m_flag = 0; m_irqen = 0; m_dmaen = 0; m_req = 0;
            m_fcnt = 0; m_cnt = 0; m_cap = 0;
        end else begin
            s2   = mq[0];
            lvl  = (flen == 0) ? s2 : m_fq;
            rise = lvl && !m_prev;
            fall = !lvl && m_prev;
            ev   = (mode == 1 && rise) || (mode == 2 && fall) || (mode == 3 && (rise || fall));
            if (ev) m_cap = m_cnt;
            if (ev && reload) m_cnt = 0;
            else if (tick) m_cnt = (m_cnt + 1) % 65536;
            if (ev) m_flag = 1; else if (fclr) m_flag = 0;
            if (ev && m_dmaen) m_req = 1; else if (rd) m_req = 0;
            if (set_irq) begin m_irqen = 1; m_dmaen = 0; end
            else if (set_dma) begin m_dmaen = 1; m_irqen = 0; end
            if (flen == 0) begin m_fq = s2; m_fcnt = 0; end
            else if (s2 == m_fq) m_fcnt = 0;
            else if (m_fcnt + 1 >= flen) begin m_fq = s2; m_fcnt = 0; end
            else m_fcnt = m_fcnt + 1;
            m_prev = lvl;
            void'(mq.pop_front());
            mq.push_back(pins[sel] ^ inv);
        end
    end

    task automatic check(string req, string what, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (chk_on && !done) begin
            check("R4", "cap_o", cap, m_cap);
            check("R5", "cnt_o", cnt, m_cnt);
            check("R6", "flag_o", flag, m_flag);
            check("R7", "irq_o", irq, m_flag & m_irqen);
            check("R8", "dma_o", dma, m_req & m_dmaen);
            check("R9", "pin_oe_o", oe, (mode == 0) ? oe_req : 1'b0);
        end
    end

    task automatic step(int n = 1);
        repeat (n) @(negedge clk);
        #2;
    endtask

    task automatic clear_flag();
        fclr = 1; step(); fclr = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++; tests++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        step(3);
        rst = 0;
        step();
        chk_on = 1;
        // R11: reset state
        check("R11", "reset cnt", cnt, 0);
        check("R11", "reset cap", cap, 0);
        check("R11", "reset flag", {flag, irq, dma}, 0);

        // R2: latency through two synchronizer stages
        mode = 1; tick = 1; step(4);
        clear_flag(); step(2);
        pins[0] = 1;
        @(negedge clk);
        @(negedge clk);
        check("R2", "flag after two edges", flag, 0);
        @(negedge clk);
        check("R2", "flag after three edges", flag, 1);
        #2;

        // R1: unselected pin ignored, inversion applied
        pins = '0; mode = 3; step(5);
        clear_flag();
        sel = 2;
        for (int i = 0; i < 6; i++) begin pins[0] = ~pins[0]; step(); end
        step(4);
        check("R1", "unselected pin", flag, 0);
        mode = 1; inv = 1; step(5);
        check("R1", "inverted low gives rise", flag, 1);
        inv = 0; step(5); clear_flag(); sel = 0; pins = '0; step(5);

        // R3: falling mode ignores rise
        mode = 2; step(2); clear_flag();
        pins[0] = 1; step(6);
        check("R3", "rise in fall mode", flag, 0);
        pins[0] = 0; step(6);
        check("R3", "fall in fall mode", flag, 1);

        // R5: period measurement
        mode = 1; reload = 1; tick = 1; clear_flag();
        for (int p = 0; p < 3; p++) begin
            pins[0] = 1; step(10); pins[0] = 0; step(10);
        end
        check("R5", "period capture", cap, 19);
        reload = 0;

        // R7 / R8: routing
        set_irq = 1; step(); set_irq = 0;
        set_dma = 1; step(); set_dma = 0; clear_flag(); step(2);
        pins[0] = 1; step(5);
        check("R7", "irq off under dma", irq, 0);
        check("R8", "dma raised", dma, 1);
        rd = 1; step(); rd = 0;
        check("R8", "dma cleared by read", dma, 0);
        set_irq = 1; set_dma = 1; step(); set_irq = 0; set_dma = 0;
        check("R7", "irq wins tie", irq, 1);
        pins[0] = 0; step(3);

        // R10: filter
        flen = 3; mode = 1; step(4); clear_flag();
        pins[0] = 1; step(2); pins[0] = 0; step(8);
        check("R10", "short pulse ignored", flag, 0);
        pins[0] = 1; step(5); pins[0] = 0; step(8);
        check("R10", "long pulse accepted", flag, 1);
        flen = 0; step(4);

        // R9: output enable when off
        mode = 0; oe_req = 1; step();
        check("R9", "oe passes when off", oe, 1);

        // random phase
        for (int i = 0; i < 3000; i++) begin
            pins    = 4'($urandom);
            if ($urandom_range(0, 7) == 0) sel = 2'($urandom);
            if ($urandom_range(0, 31) == 0) mode = 2'($urandom);
            if ($urandom_range(0, 31) == 0) inv = 1'($urandom);
            if ($urandom_range(0, 31) == 0) reload = 1'($urandom);
            if ($urandom_range(0, 63) == 0) flen = 4'($urandom_range(0, 4));
            tick    = 1'($urandom);
            oe_req  = 1'($urandom);
            fclr    = ($urandom_range(0, 7) == 0);
            rd      = ($urandom_range(0, 7) == 0);
            set_irq = ($urandom_range(0, 15) == 0);
            set_dma = ($urandom_range(0, 15) == 0);
            step();
        end
        fclr = 0; rd = 0; set_irq = 0; set_dma = 0;
        step(2);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule